// File: doc/BRIEF.md
# Serial Port Control Register with Transceiver Direction Sequencing

This block holds the eight-bit control word of a UART-style serial port together with the small amount of logic that the word drives directly. A plain register bus with one address writes the word and reads it back. Five enable bits gate five status flags supplied by the surrounding port logic, and the gated flags are merged into one registered interrupt request. A loop-back bit swaps the receiver input from the external receive pin to the transmitter's own serial output line.

The remaining two-bit field controls a half-duplex line driver. When either bit of the field is set, a transmit request from the port is held back one clock. During that clock a direction output, a transmit-pin output enable, or both, are raised. The start pulse reaches the transmitter on the following clock. Both signals stay up until the transmitter reports completion. A request that coincides with completion keeps the line driven without a gap. With the field at zero, requests pass straight through, the output enable is held on and the direction output stays low.

Baud timing, shifting, framing and the status flag logic live outside this block.

Top module: `serial_ctl_top`

## Requirements
- R1: After reset the control word reads 0x00, the interrupt output is 0, the direction output is 0, the output enable is 1 and the start output is 0.
- R2: A write presented with `cfg_wr` high is stored at the clock edge, and all eight bits read back unchanged on `cfg_rdata` from the next cycle.
- R3: Control word layout: bit 7 enables receive-complete, bit 6 transmit-complete, bit 5 data-register-empty, bit 4 receive-start-frame, bit 3 is loop-back, bit 2 enables the auto-baud error, and bits 1:0 are the line-driver mode. `st_flags` carries receive-complete on bit 4, transmit-complete on bit 3, data-register-empty on bit 2, receive-start-frame on bit 1 and auto-baud error on bit 0.
- R4: `irq_o` is 1 exactly one cycle after any status flag is 1 while its enable is 1, and is 0 one cycle after no enabled flag is set.
- R5: With loop-back set, `rx_data_o` follows `txd_line` and ignores `rxd_pin`. With loop-back clear, it follows `rxd_pin`.
- R6: With mode bit 0 set, `xdir_o` rises in the cycle after a transmit request is sampled, and `tx_start_o` pulses for one cycle in the cycle after that.
- R7: With mode bit 1 set, `txd_oe_o` is 0 while idle, rises in the cycle after a request is sampled, and the start pulse follows one cycle later.
- R8: In the cycle after `tx_done_i` is sampled with no new request, `xdir_o` returns to 0 and `txd_oe_o` returns to its idle value.
- R9: A request sampled together with `tx_done_i` keeps the direction and enable outputs asserted with no gap, and issues the start pulse in the next cycle with no fresh lead cycle.
- R10: With mode 00, `tx_start_o` equals `tx_req_i` in the same cycle, `txd_oe_o` is 1 and `xdir_o` is 0.
- R11: With mode 11, `xdir_o` and `txd_oe_o` rise and fall in the same cycles.
- R12: A request arriving while a lead cycle or a frame is in progress, and not together with `tx_done_i`, produces no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Current control word |
| st_flags | input | 5 | Status flags from the port logic |
| irq_o | output | 1 | Registered combined interrupt request |
| rxd_pin | input | 1 | External receive pin |
| txd_line | input | 1 | Transmitter serial output |
| rx_data_o | output | 1 | Serial input to the receiver |
| tx_req_i | input | 1 | Transmit request from the port |
| tx_done_i | input | 1 | Transmit-complete pulse from the transmitter |
| tx_start_o | output | 1 | Start pulse to the transmitter |
| xdir_o | output | 1 | Line-driver direction output |
| txd_oe_o | output | 1 | Output enable for the transmit pin |

## Verification
On every cycle, the assertions check four things. A write lands in the read-back, the interrupt follows the gated flags one cycle later, every start pulse in a driven mode is preceded by an asserted driver, and completion either releases the driver or continues it with no gap. Other behaviour appears only in the bench's scenarios. This covers the exact bit positions of each enable and flag, and the loop-back mux choosing between its two sources. It also covers the same-cycle pass-through in mode 00, the idle level of the output enable in each mode, and the dropping of requests that arrive mid-frame.

// File: rtl/scp_pkg.sv
package scp_pkg;
   localparam int CTL_W  = 8;
   localparam int IRQ_N  = 5;

   typedef struct packed {
      logic       en_rxc;
      logic       en_txc;
      logic       en_dre;
      logic       en_rxs;
      logic       loop_en;
      logic       en_abe;
      logic [1:0] drv_mode;
   } scp_ctl_t;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LEAD = 2'd1,
      SEQ_BUSY = 2'd2
   } seq_state_e;

   function automatic logic [IRQ_N-1:0] irq_enables(input scp_ctl_t c);
      return {c.en_rxc, c.en_txc, c.en_dre, c.en_rxs, c.en_abe};
   endfunction
endpackage

// File: rtl/scp_ctlreg.sv
module scp_ctlreg
   import scp_pkg::*;
#(
   parameter int          W         = CTL_W,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] rd_data
);
   generate
      if (W != CTL_W) begin : g_bad_width
         $error("scp_ctlreg: width must match the control word");
      end
   endgenerate

   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= RESET_VAL;
      else if (wr_en) word_q <= wr_data;
   end

   assign rd_data = word_q;

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == $past(wr_data)));  // R2
endmodule

// File: rtl/scp_irqcomb.sv
module scp_irqcomb #(
   parameter int N          = 5,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] enables,
   output logic         irq
);
   generate
      if (N < 1) begin : g_bad_n
         $error("scp_irqcomb: at least one source needed");
      end
   endgenerate

   logic [N-1:0] gated;
   logic         any_hit;

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_gate
         assign gated[i] = flags[i] & enables[i];
      end
   endgenerate

   assign any_hit = |gated;

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_hit;
         end
         assign irq = irq_q;

         AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            (|(flags & enables)) |=> irq);  // R4
         AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(flags & enables)) |=> !irq);  // R4
      end else begin : g_comb
         assign irq = any_hit;
      end
   endgenerate
endmodule

// File: rtl/scp_dirseq.sv
module scp_dirseq
   import scp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       tx_req,
   input  logic       tx_done,
   output logic       tx_start,
   output logic       xdir,
   output logic       txd_oe
);
   seq_state_e state_q, state_d;
   logic       start_q, start_d;
   logic       mode_nz;
   logic       dir_on;
   logic       chain;

   assign mode_nz = |mode;
   assign chain   = (state_q == SEQ_BUSY) && tx_done && tx_req;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE: if (tx_req) state_d = SEQ_LEAD;
         SEQ_LEAD: state_d = SEQ_BUSY;
         SEQ_BUSY: if (tx_done && !tx_req) state_d = SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
      if (!mode_nz) state_d = SEQ_IDLE;
   end

   assign start_d = mode_nz && ((state_q == SEQ_LEAD) || chain);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= start_d;
      end
   end

   assign dir_on   = (state_q != SEQ_IDLE);
   assign tx_start = mode_nz ? start_q : tx_req;
   assign xdir     = mode[0] & dir_on;
   assign txd_oe   = ~mode[1] | dir_on;

   AST_LEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && mode_nz && $stable(mode)) |-> $past(dir_on));  // R6
   AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && mode_nz) |=> !start_q);  // R6
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_BUSY) && tx_done && !tx_req) |=> !dir_on);  // R8
   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_BUSY) && tx_done && tx_req && mode_nz) |=> (dir_on && start_q));  // R9
endmodule

// File: rtl/serial_ctl_top.sv
module serial_ctl_top
   import scp_pkg::*;
#(
   parameter logic [CTL_W-1:0] CTL_RESET      = 8'h00,
   parameter bit               IRQ_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CTL_W-1:0] cfg_wdata,
   output logic [CTL_W-1:0] cfg_rdata,
   input  logic [IRQ_N-1:0] st_flags,
   output logic             irq_o,
   input  logic             rxd_pin,
   input  logic             txd_line,
   output logic             rx_data_o,
   input  logic             tx_req_i,
   input  logic             tx_done_i,
   output logic             tx_start_o,
   output logic             xdir_o,
   output logic             txd_oe_o
);
   generate
      if ($bits(scp_ctl_t) != CTL_W) begin : g_bad_layout
         $error("serial_ctl_top: control layout width mismatch");
      end
   endgenerate

   logic [CTL_W-1:0] word;
   scp_ctl_t         ctl;

   scp_ctlreg #(.W(CTL_W), .RESET_VAL(CTL_RESET)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr),
      .wr_data(cfg_wdata),
      .rd_data(word)
   );

   assign ctl       = scp_ctl_t'(word);
   assign cfg_rdata = word;

   scp_irqcomb #(.N(IRQ_N), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (st_flags),
      .enables(irq_enables(ctl)),
      .irq    (irq_o)
   );

   assign rx_data_o = ctl.loop_en ? txd_line : rxd_pin;

   scp_dirseq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (ctl.drv_mode),
      .tx_req  (tx_req_i),
      .tx_done (tx_done_i),
      .tx_start(tx_start_o),
      .xdir    (xdir_o),
      .txd_oe  (txd_oe_o)
   );
endmodule

// File: tb/serial_ctl_top_test.sv
module serial_ctl_top_test;
   localparam time PERIOD = 10ns;
   localparam int  NVEC   = 8;
   // {control word, flags, expected irq}
   localparam logic [13:0] VEC [NVEC] = '{
      {8'h00, 5'h1F, 1'b0},
      {8'h80, 5'h10, 1'b1},
      {8'h80, 5'h0F, 1'b0},
      {8'h40, 5'h08, 1'b1},
      {8'h20, 5'h04, 1'b1},
      {8'h10, 5'h02, 1'b1},
      {8'h04, 5'h01, 1'b1},
      {8'h7B, 5'h10, 1'b0}
   };

   logic       clk = 0, rst_n = 0;
   logic       cfg_wr = 0;
   logic [7:0] cfg_wdata = 0, cfg_rdata;
   logic [4:0] st_flags = 0;
   logic       irq_o, rxd_pin = 0, txd_line = 0, rx_data_o;
   logic       tx_req_i = 0, tx_done_i = 0, tx_start_o, xdir_o, txd_oe_o;
   int         n_run = 0, n_fail = 0;
   bit         finished = 0;

   serial_ctl_top uut (.*);

   always #(PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] v);
      cfg_wdata = v; cfg_wr = 1; tick(); cfg_wr = 0;
   endtask

   task automatic frame(input logic [1:0] m, input string tag);
      wr({6'b0, m});
      chk({tag, " idle xdir"}, xdir_o, 0);
      chk({tag, " R7 idle oe"}, txd_oe_o, !m[1]);
      tx_req_i = 1; #1;
      chk({tag, " R6 no same-cycle start"}, tx_start_o, 0);
      tick(); tx_req_i = 0;
      chk({tag, " R6 lead xdir"}, xdir_o, m[0]);
      chk({tag, " R7 lead oe"}, txd_oe_o, 1);
      chk({tag, " R6 lead no start"}, tx_start_o, 0);
      tick();
      chk({tag, " R6 start pulse"}, tx_start_o, 1);
      chk({tag, " R11 xdir hold"}, xdir_o, m[0]);
      chk({tag, " R11 oe hold"}, txd_oe_o, 1);
      tick();
      chk({tag, " R6 single pulse"}, tx_start_o, 0);
      tx_req_i = 1; tick(); tx_req_i = 0;
      chk({tag, " R12 ignored req"}, tx_start_o, 0);
      chk({tag, " R12 still driven"}, txd_oe_o & (xdir_o | !m[0]), 1);
      tx_req_i = 1; tx_done_i = 1; tick(); tx_req_i = 0; tx_done_i = 0;
      chk({tag, " R9 chained start"}, tx_start_o, 1);
      chk({tag, " R9 xdir no gap"}, xdir_o, m[0]);
      chk({tag, " R9 oe no gap"}, txd_oe_o, 1);
      tick();
      chk({tag, " R9 chained single"}, tx_start_o, 0);
      tx_done_i = 1; tick(); tx_done_i = 0;
      chk({tag, " R8 xdir release"}, xdir_o, 0);
      chk({tag, " R8 oe release"}, txd_oe_o, !m[1]);
      chk({tag, " R11 same edge"}, xdir_o | (txd_oe_o ^ !m[1]), 0);
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 2); #1;
      chk("R1 rdata", cfg_rdata, 8'h00);
      chk("R1 oe", txd_oe_o, 1);
      rst_n = 1; tick();
      chk("R1 rdata after release", cfg_rdata, 8'h00);
      chk("R1 irq", irq_o, 0);
      chk("R1 xdir", xdir_o, 0);
      chk("R1 start", tx_start_o, 0);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][13:6]);
         chk("R2 readback", cfg_rdata, VEC[i][13:6]);
         st_flags = VEC[i][5:1];
         tick();
         chk("R3 R4 irq gating", irq_o, VEC[i][0]);
      end
      st_flags = 0; tick();
      chk("R4 irq clears", irq_o, 0);
      wr(8'hA5); chk("R2 all bits", cfg_rdata, 8'hA5);
      wr(8'h5A); chk("R2 all bits inv", cfg_rdata, 8'h5A);

      wr(8'h80); st_flags = 5'h10; #1;
      chk("R4 one-cycle latency", irq_o, 0);
      tick(); chk("R4 raised", irq_o, 1);
      wr(8'h00); tick(); chk("R4 enable drop", irq_o, 0);
      st_flags = 0;

      wr(8'h08);
      txd_line = 1; rxd_pin = 0; #1; chk("R5 loop txd=1", rx_data_o, 1);
      txd_line = 0; rxd_pin = 1; #1; chk("R5 loop ignores rxd", rx_data_o, 0);
      wr(8'h00);
      rxd_pin = 1; txd_line = 0; #1; chk("R5 normal rxd=1", rx_data_o, 1);
      rxd_pin = 0; txd_line = 1; #1; chk("R5 normal rxd=0", rx_data_o, 0);

      tx_req_i = 1; #1;
      chk("R10 pass-through", tx_start_o, 1);
      chk("R10 oe held", txd_oe_o, 1);
      chk("R10 xdir low", xdir_o, 0);
      tick(); tx_req_i = 0; #1;
      chk("R10 follows low", tx_start_o, 0);
      chk("R10 xdir stays low", xdir_o, 0);

      frame(2'b01, "mode01");
      frame(2'b10, "mode10");
      frame(2'b11, "mode11 R11");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule